// File: doc/BRIEF.md
# Type-0 PCI Configuration Address Translator

This block turns a processor access that falls inside a configuration window into the address of a type-0 PCI configuration cycle. The access supplies the low 16 bits of its address. A 32-bit mapping register supplies the upper half of a combined 32-bit working address. Bits 31 down to 11 of that working address form a one-hot select field. The device number is the position of the lowest set bit in that field, counted from bit 11. The function and register numbers come straight from the lower bits.

Every request produces a registered result one clock later. The result is one of three things. It can be a forwarded access, carrying a finished configuration address with the enable bit set. It can be an unsupported access, used when the mapping register asks for type-1 cycles; a read then gets an all-ones fill pattern sized to the access. It can be an error, used when the select field is empty. A forwarded access also raises a one-cycle request to clear the bridge's own received-master-abort and received-target-abort status bits.

Top module: `cfg_type0_xlat`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero.
- R2: `res_valid` is high exactly one cycle after a cycle with `req_valid` high, and low otherwise. When `res_valid` is low, all other outputs are zero.
- R3: If bit 16 of `map_reg` is set, the result has `res_unsup`=1 and `res_fwd`=0, `res_err`=0, `res_clr_abort`=0 and `res_addr`=0.
- R4: The result of an unsupported read has `res_fill` equal to all ones over the access size. `req_size` 0 gives 0x000000FF, 1 gives 0x0000FFFF, and 2 or 3 give 0xFFFFFFFF. Every other result, including an unsupported write, has `res_fill`=0.
- R5: The working address W is `{map_reg[15:0], req_addr[15:0]}`. For a forwarded access, `res_addr[15:11]` is the index of the lowest set bit of W[31:11]. Higher select bits have no effect on it.
- R6: For a forwarded access, `res_addr[10:8]` equals W[10:8], `res_addr[7:2]` equals W[7:2], and `res_addr[1:0]` is 0.
- R7: For a forwarded access, `res_addr[31]` is 1, `res_addr[30:24]` is 0, and `res_addr[23:16]` equals `bus_num` as sampled with the request.
- R8: If bit 16 of `map_reg` is clear and W[31:11] is zero, the result has `res_err`=1, `res_fwd`=0, `res_clr_abort`=0 and `res_addr`=0.
- R9: Every forwarded access, read or write, has `res_clr_abort`=1 in its result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_addr | input | 16 | Low 16 bits of the access address |
| map_reg | input | 32 | Mapping register: [15:0] upper working address, [16] type-1 request |
| bus_num | input | 8 | Bus number placed into the configuration address |
| res_valid | output | 1 | Result present |
| res_fwd | output | 1 | Access is forwarded with `res_addr` |
| res_unsup | output | 1 | Access rejected as unsupported |
| res_err | output | 1 | Empty select field |
| res_addr | output | 32 | Configuration address |
| res_fill | output | 32 | Read data returned for a rejected read |
| res_clr_abort | output | 1 | Request to clear the received-abort status bits |

## Verification
The bench walks a single select bit across all 21 positions, with every function number and several register numbers. It then repeats the walk with extra higher select bits set. A design that took the highest bit, or that did not subtract the base offset, would show a wrong device field. Register numbers with the low two address bits set catch a design that leaks those bits into the register field. Unsupported accesses are run across all sizes and both directions, so a fill mask that ignores the direction or the size is caught. An empty select field combined with type-1 mode checks that the unsupported result takes precedence over the error.

// File: rtl/cfg_type0_xlat.sv
module cfg_type0_xlat #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [15:0]      req_addr,
  input  logic [31:0]      map_reg,
  input  logic [BUS_W-1:0] bus_num,
  output logic             res_valid,
  output logic             res_fwd,
  output logic             res_unsup,
  output logic             res_err,
  output logic [31:0]      res_addr,
  output logic [31:0]      res_fill,
  output logic             res_clr_abort
);
  localparam int SEL_LSB = 11;
  localparam int SEL_W   = 32 - SEL_LSB;

  logic [31:0]      work;
  logic [SEL_W-1:0] sel;
  logic [4:0]       dev;
  logic             unsup, empty, fwd;
  logic [31:0]      addr_c, fill_c;

  assign work  = {map_reg[15:0], req_addr};
  assign sel   = work[31:SEL_LSB];
  assign unsup = map_reg[16];
  assign empty = (sel == '0);
  assign fwd   = !unsup && !empty;

  always_comb begin
    dev = '0;
    for (int i = SEL_W - 1; i >= 0; i--)
      if (sel[i]) dev = 5'(i);
  end

  assign addr_c = {1'b1, 7'd0, 8'(bus_num), dev, work[10:8], work[7:2], 2'b00};

  always_comb begin
    case (req_size)
      2'd0:    fill_c = 32'h0000_00FF;
      2'd1:    fill_c = 32'h0000_FFFF;
      default: fill_c = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_fwd       <= 1'b0;
      res_unsup     <= 1'b0;
      res_err       <= 1'b0;
      res_addr      <= '0;
      res_fill      <= '0;
      res_clr_abort <= 1'b0;
    end else begin
      res_valid     <= req_valid;
      res_fwd       <= req_valid && fwd;
      res_unsup     <= req_valid && unsup;
      res_err       <= req_valid && !unsup && empty;
      res_addr      <= (req_valid && fwd) ? addr_c : '0;
      res_fill      <= (req_valid && unsup && !req_write) ? fill_c : '0;
      res_clr_abort <= req_valid && fwd;
    end
  end
endmodule

// File: rtl/cfg_type0_xlat_chk.sv
module cfg_type0_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [31:0] map_reg,
  input logic        res_valid,
  input logic        res_fwd,
  input logic        res_unsup,
  input logic        res_err,
  input logic [31:0] res_addr,
  input logic [31:0] res_fill,
  input logic        res_clr_abort
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !res_fwd && !res_unsup && !res_err);
  assert_unsup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && map_reg[16] |=> res_unsup && !res_fwd && !res_clr_abort && res_addr == 32'd0);
  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> res_fill == 32'd0);
  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_fwd |-> res_addr[31] && res_addr[30:24] == 7'd0);
  assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !map_reg[16] && map_reg[15:0] == 16'd0 && req_addr[15:11] == 5'd0
    |=> res_err && !res_fwd && !res_clr_abort);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !map_reg[16] && (map_reg[15:0] != 16'd0 || req_addr[15:11] != 5'd0)
    |=> res_clr_abort && res_fwd);
  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_fwd, res_unsup, res_err}));
endmodule

bind cfg_type0_xlat cfg_type0_xlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .map_reg(map_reg), .res_valid(res_valid),
  .res_fwd(res_fwd), .res_unsup(res_unsup), .res_err(res_err),
  .res_addr(res_addr), .res_fill(res_fill), .res_clr_abort(res_clr_abort)
);

// File: tb/cfg_type0_xlat_bench.sv
module cfg_type0_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] map_reg = '0;
  logic [7:0]  bus_num = '0;
  logic        res_valid, res_fwd, res_unsup, res_err, res_clr_abort;
  logic [31:0] res_addr, res_fill;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_type0_xlat u_cfg_type0_xlat (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] work,
                        input logic unsup_bit, input logic [7:0] bus);
    logic [31:0] exp_addr, exp_fill;
    logic [4:0]  dev;
    logic        empty;
    empty = (work[31:11] == 21'd0);
    dev = '0;
    for (int i = 20; i >= 0; i--) if (work[11+i]) dev = 5'(i);
    exp_addr = 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11) | (work & 32'h0000_07FC);
    exp_fill = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = work[15:0];
    map_reg = {15'h5A5A, unsup_bit, work[31:16]};
    bus_num = bus;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 valid", 32'(res_valid), 32'd1);
    if (unsup_bit) begin
      chk("R3 unsup", {res_unsup, res_fwd, res_err, res_clr_abort}, 32'b1000);
      chk("R3 addr", res_addr, 32'd0);
      chk("R4 fill", res_fill, wr ? 32'd0 : exp_fill);
    end else if (empty) begin
      chk("R8 err", {res_unsup, res_fwd, res_err, res_clr_abort}, 32'b0010);
      chk("R8 addr", res_addr, 32'd0);
      chk("R4 nofill", res_fill, 32'd0);
    end else begin
      chk("R9 fwd_clr", {res_unsup, res_fwd, res_err, res_clr_abort}, 32'b0101);
      chk("R5 dev", 32'(res_addr[15:11]), 32'(dev));
      chk("R6 fn_reg", 32'(res_addr[10:0]), exp_addr & 32'h7FF);
      chk("R7 hdr", res_addr & 32'hFFFF_0000, exp_addr & 32'hFFFF_0000);
      chk("R4 nofill", res_fill, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {res_valid, res_fwd, res_unsup, res_err, res_clr_abort}, 32'd0);
    chk("R1 reset addr", res_addr | res_fill, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res_valid, res_fwd, res_unsup, res_err, res_clr_abort}, 32'd0);
    for (int pos = 0; pos < 21; pos++)
      for (int fn = 0; fn < 8; fn++)
        for (int r = 0; r < 4; r++) begin
          logic [31:0] w;
          w = (32'd1 << (11 + pos)) | (32'(fn) << 8) | (32'(r * 21 % 64) << 2) | 32'(r);
          access(r[0], 2'(r), w, 1'b0, 8'(pos * 13 + fn));
          w = w | ~((32'd2 << (11 + pos)) - 32'd1);
          access(fn[0], 2'(fn), w, 1'b0, 8'(255 - pos));
        end
    for (int sz = 0; sz < 4; sz++)
      for (int wr = 0; wr < 2; wr++) begin
        access(wr[0], 2'(sz), 32'h0042_0F37, 1'b1, 8'h11);
        access(wr[0], 2'(sz), 32'h0000_07FF, 1'b1, 8'h22);
      end
    for (int fn = 0; fn < 8; fn++)
      access(fn[0], 2'd2, (32'(fn) << 8) | 32'hFF, 1'b0, 8'h33);
    @(negedge clk);
    chk("R2 idle", {res_valid, res_fwd, res_unsup, res_err, res_clr_abort}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule